// File: doc/BRIEF.md
# Debug Mailbox Register with Shared I/O Slot

This block carries single bytes from software running on a processor core to an external debug probe. The core writes a byte to one I/O address. The block keeps the byte and raises a pending flag. The probe reads the byte and acknowledges it, which drops the flag. When the core reads the same address it gets the low seven stored bits, with the pending flag in place of bit 7. Software can therefore poll whether the probe has taken the last byte.

The mailbox shares its address with an ordinary general-purpose I/O register. The mailbox is visible only while both the debug fuse input and the probe's access-enable input are high. In every other case, core reads and writes at that address go to the ordinary register.

The probe side works as a stream source. `dbg_valid` is the pending flag, and `dbg_ready` is the probe's acknowledge. A byte stays on `dbg_data` and `dbg_valid` stays high until the probe raises `dbg_ready`. There is no back-pressure toward the core: a new core write replaces an unacknowledged byte and keeps `dbg_valid` high.

Top module: `dbg_mailbox_top`

## Requirements
- R1: A core write (`cpu_wr`) to I/O address 0x31 while both enables are high stores `cpu_wdata` and sets `dbg_valid`. Both are visible after the next clock edge.
- R2: A core read (`cpu_rd`) of 0x31 while the mailbox is enabled returns the pending flag in bit 7 and stored bits 6..0 in bits 6..0. The value is on `cpu_rdata` one clock after the read strobe.
- R3: Core reads of the mailbox never clear `dbg_valid`.
- R4: `dbg_ready` high for one cycle clears `dbg_valid` after the next edge and leaves the stored byte unchanged.
- R5: When a mailbox write and `dbg_ready` fall in the same cycle, the new byte is stored and `dbg_valid` stays high.
- R6: `dbg_data` always shows all eight stored bits, including bit 7.
- R7: When either `dbg_fuse_en` or `dbg_access_en` is low, reads and writes at 0x31 reach the ordinary I/O register. A read returns all eight of its bits.
- R8: Writes routed to the ordinary register leave the mailbox byte and `dbg_valid` unchanged.
- R9: Synchronous active-high `rst` clears the mailbox byte, the ordinary register, `dbg_valid` and `cpu_rdata` to zero.
- R10: Accesses to any address other than 0x31 return 0x00 one clock after the read strobe and change no stored state.
- R11: In a cycle that follows one without a read strobe, `cpu_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 6 | Core I/O address |
| cpu_wr | input | 1 | Core write strobe |
| cpu_rd | input | 1 | Core read strobe |
| cpu_wdata | input | 8 | Core write data |
| cpu_rdata | output | 8 | Registered core read data |
| dbg_fuse_en | input | 1 | Debug fuse state |
| dbg_access_en | input | 1 | Probe grants mailbox access |
| dbg_ready | input | 1 | Probe has taken the byte (acknowledge) |
| dbg_valid | output | 1 | Pending flag: byte not yet taken |
| dbg_data | output | 8 | Full stored mailbox byte |

## Verification
The bench writes bytes with bit 7 set and then clear. This catches a design that stores the flag into the data or hides bit 7 from the probe. It places a write and an acknowledge in the same cycle, where a design with the wrong priority would drop the pending flag and lose the byte. It turns off each enable in turn to confirm that writes land in the ordinary register without touching the mailbox. It also writes to an unrelated address, which would expose a decoder that ignores upper address bits.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MBOX = 2'd1,
    TGT_STD  = 2'd2
  } tgt_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import dbg_mbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fuse_en,
  input  logic              access_en,
  output tgt_e              tgt
);
  logic hit;
  assign hit = (addr == MBOX_ADDR);

  always_comb begin
    if (!hit)                      tgt = TGT_NONE;
    else if (fuse_en && access_en) tgt = TGT_MBOX;
    else                           tgt = TGT_STD;
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic [DATA_W-1:0] data_q,
  output logic              dirty_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (wr_en) data_q <= wdata;
      // a fresh byte outranks the acknowledge
      if (wr_en)    dirty_q <= 1'b1;
      else if (clr) dirty_q <= 1'b0;
    end
  end
endmodule

// File: rtl/std_io_reg.sv
module std_io_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata;
  end
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port
  import dbg_mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] mbox_data,
  input  logic              dirty,
  input  logic [DATA_W-1:0] std_data,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mbox_view;
  logic [DATA_W-1:0] rd_next;

  // top bit of the core view carries the pending flag
  assign mbox_view = {dirty, mbox_data[DATA_W-2:0]};

  always_comb begin
    rd_next = '0;
    if (rd) begin
      unique case (tgt)
        TGT_MBOX: rd_next = mbox_view;
        TGT_STD:  rd_next = std_data;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end
endmodule

// File: rtl/dbg_mailbox_top.sv
module dbg_mailbox_top
  import dbg_mbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dbg_fuse_en,
  input  logic              dbg_access_en,
  input  logic              dbg_ready,
  output logic              dbg_valid,
  output logic [DATA_W-1:0] dbg_data
);
  tgt_e              tgt;
  logic              mbox_wr;
  logic              std_wr;
  logic [DATA_W-1:0] std_q;

  mbox_decode #(.ADDR_W(ADDR_W), .MBOX_ADDR(MBOX_ADDR)) u_dec (
    .addr(cpu_addr), .fuse_en(dbg_fuse_en), .access_en(dbg_access_en), .tgt(tgt)
  );

  assign mbox_wr = cpu_wr && (tgt == TGT_MBOX);
  assign std_wr  = cpu_wr && (tgt == TGT_STD);

  mbox_store #(.DATA_W(DATA_W)) u_mbox (
    .clk(clk), .rst(rst), .wr_en(mbox_wr), .wdata(cpu_wdata),
    .clr(dbg_ready), .data_q(dbg_data), .dirty_q(dbg_valid)
  );

  std_io_reg #(.DATA_W(DATA_W)) u_std (
    .clk(clk), .rst(rst), .wr_en(std_wr), .wdata(cpu_wdata), .q(std_q)
  );

  mbox_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd(cpu_rd), .tgt(tgt),
    .mbox_data(dbg_data), .dirty(dbg_valid), .std_data(std_q), .rdata_q(cpu_rdata)
  );
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              dbg_fuse_en,
  input logic              dbg_access_en,
  input logic              dbg_ready,
  input logic              dbg_valid,
  input logic [DATA_W-1:0] dbg_data
);
  logic on_slot;
  logic open_box;
  assign on_slot  = (cpu_addr == MBOX_ADDR);
  assign open_box = dbg_fuse_en && dbg_access_en;

  p_wr_sets_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && on_slot && open_box) |=> (dbg_valid && dbg_data == $past(cpu_wdata)));

  p_flag_sticks_r3: assert property (@(posedge clk) disable iff (rst)
    (dbg_valid && !dbg_ready) |=> dbg_valid);

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (dbg_ready && !(cpu_wr && on_slot && open_box)) |=> (!dbg_valid && $stable(dbg_data)));

  p_write_beats_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && on_slot && open_box && dbg_ready) |=> dbg_valid);

  p_closed_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!open_box && !dbg_ready) |=> ($stable(dbg_data) && $stable(dbg_valid)));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (dbg_data == '0 && !dbg_valid && cpu_rdata == '0));

  p_other_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !on_slot) |=> (cpu_rdata == '0));

  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> (cpu_rdata == '0));
endmodule

bind dbg_mailbox_top dbg_mailbox_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBOX_ADDR(MBOX_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dbg_fuse_en(dbg_fuse_en),
  .dbg_access_en(dbg_access_en), .dbg_ready(dbg_ready), .dbg_valid(dbg_valid),
  .dbg_data(dbg_data)
);

// File: tb/sim_dbg_mailbox_top.sv
module sim_dbg_mailbox_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       dbg_fuse_en = 1'b0;
  logic       dbg_access_en = 1'b0;
  logic       dbg_ready = 1'b0;
  logic       dbg_valid;
  logic [7:0] dbg_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  dbg_mailbox_top u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dbg_fuse_en(dbg_fuse_en),
    .dbg_access_en(dbg_access_en), .dbg_ready(dbg_ready), .dbg_valid(dbg_valid),
    .dbg_data(dbg_data)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= cpu_rd;

  // monitor: compare each read result one clock after its strobe
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
    end
  end

  task automatic cpu_write(input logic [5:0] a, input logic [7:0] d, input bit ack);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; dbg_ready = ack;
    @(negedge clk);
    cpu_wr = 1'b0; dbg_ready = 1'b0;
  endtask

  task automatic cpu_read(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic probe_ack();
    @(negedge clk);
    dbg_ready = 1'b1;
    @(negedge clk);
    dbg_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 data", dbg_data, 8'h00);
    check("R9 valid", {7'd0, dbg_valid}, 8'h00);
    check("R9 rdata", cpu_rdata, 8'h00);
    dbg_fuse_en = 1'b1; dbg_access_en = 1'b1;
    cpu_read(6'h31, 8'h00, "R9 mbox read");

    // R1 write stores and flags
    cpu_write(6'h31, 8'h5A, 1'b0);
    check("R1 valid", {7'd0, dbg_valid}, 8'h01);
    check("R1 data", dbg_data, 8'h5A);
    cpu_read(6'h31, 8'hDA, "R2 flag in bit7");
    check("R3 valid after read", {7'd0, dbg_valid}, 8'h01);
    cpu_read(6'h31, 8'hDA, "R3 second read");
    probe_ack();
    check("R4 valid cleared", {7'd0, dbg_valid}, 8'h00);
    check("R4 data kept", dbg_data, 8'h5A);
    cpu_read(6'h31, 8'h5A, "R2 flag low");

    // R6 bit 7 visible to probe only
    cpu_write(6'h31, 8'hC3, 1'b0);
    check("R6 full byte", dbg_data, 8'hC3);
    probe_ack();
    cpu_read(6'h31, 8'h43, "R6 core view");

    // R5 write and ack together
    cpu_write(6'h31, 8'h11, 1'b1);
    check("R5 valid kept", {7'd0, dbg_valid}, 8'h01);
    check("R5 data", dbg_data, 8'h11);

    // R7 / R8 closed mailbox
    dbg_access_en = 1'b0;
    cpu_write(6'h31, 8'h77, 1'b0);
    check("R8 data held", dbg_data, 8'h11);
    check("R8 valid held", {7'd0, dbg_valid}, 8'h01);
    cpu_read(6'h31, 8'h77, "R7 std read access off");
    dbg_access_en = 1'b1; dbg_fuse_en = 1'b0;
    cpu_write(6'h31, 8'hF0, 1'b0);
    check("R8 data held fuse off", dbg_data, 8'h11);
    cpu_read(6'h31, 8'hF0, "R7 std read fuse off");
    dbg_fuse_en = 1'b1;
    cpu_read(6'h31, 8'h91, "R8 mailbox intact");

    // R10 unrelated address
    cpu_write(6'h10, 8'hFF, 1'b0);
    check("R10 mbox untouched", dbg_data, 8'h11);
    cpu_read(6'h10, 8'h00, "R10 other read");
    cpu_write(6'h11, 8'h3C, 1'b0);
    cpu_read(6'h21, 8'h00, "R10 near address");
    dbg_fuse_en = 1'b0;
    cpu_read(6'h31, 8'hF0, "R10 std untouched");
    dbg_fuse_en = 1'b1;

    // R11 idle output
    @(negedge clk);
    @(negedge clk);
    check("R11 idle rdata", cpu_rdata, 8'h00);

    // R9 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 data after rst", dbg_data, 8'h00);
    check("R9 valid after rst", {7'd0, dbg_valid}, 8'h00);
    dbg_fuse_en = 1'b0;
    cpu_read(6'h31, 8'h00, "R9 std after rst");
    repeat (3) @(negedge clk);
    check("queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule